// File: doc/BRIEF.md
# Four-Axis Digital-Integration Pulse Generator

This block performs the fine interpolation stage of a multi-axis motion controller. A host processor plans the trajectory and, for each short move segment, hands the block one unsigned increment per axis. On a start command the block latches the increments, clears every axis accumulator and arms a step counter. Each strobe from the interpolation timer then adds every latched increment into its own accumulator. A carry out of an accumulator's top bit produces one output pulse on that axis. The accumulator keeps the low bits as the remainder for the next addition.

The step counter is armed with 2^N for N-bit accumulators. Over one move, an axis with increment K therefore emits exactly K pulses, spread as evenly as integer arithmetic allows. Pulse direction and velocity shaping stay with the host.

A three-state sequencer paces the work. An idle state waits for start. A check state clears the pulses and tests the remaining step count. An accumulate state waits for a timer strobe and does one addition. The busy flag covers the whole move. Start and tick are plain single-cycle control strobes with no handshake. A start arriving while busy is dropped.

Top module: `dda_pulse_gen`

## Requirements
- R1: After reset, busy is 0, every axis pulse is 0 and the remaining step count is 0.
- R2: A start while idle sets busy on the next clock and loads a remaining step count of 2^N, where N is the accumulator width.
- R3: Over one move, axis a emits exactly K_a pulses, where K_a is the N-bit unsigned field of the increment bus at bits [a*N +: N] when start was accepted.
- R4: A pulse lasts exactly one clock, and no axis pulses in two consecutive clocks.
- R5: While busy and with tick low, no accumulation occurs: the remaining count holds and no pulse follows.
- R6: A start received while busy is ignored: the count is not reloaded and the move's pulse totals are unchanged.
- R7: Each accepted tick lowers the remaining count by exactly one. Busy falls one clock after the count reaches 0, when the block returns to idle.
- R8: Changes on the increment bus after start has been accepted have no effect on the current move.
- R9: An increment of 0 yields no pulses on that axis, and the maximum increment 2^N-1 yields 2^N-1 pulses.
- R10: Ticks while idle have no effect: busy, pulses and the count all stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-move strobe, accepted only while idle |
| tick_i | input | 1 | Interpolation timer strobe, paces each accumulation |
| incr_i | input | NUM_AXES*ACC_W | Per-axis increments, axis a at bits [a*ACC_W +: ACC_W] |
| busy_o | output | 1 | High from accepted start until the move completes |
| pulse_o | output | NUM_AXES | One-clock step pulse per axis |
| steps_left_o | output | ACC_W+1 | Remaining accumulations in the current move |

## Verification
The bench builds the block with four axes and a 4-bit accumulator. A move then takes 16 accepted ticks, and every increment value from 0 to the maximum 15 fits in a short run. This puts the exact-count property and both increment extremes within reach of a table of increment words.

The table entries vary the spacing of the timer strobes, so ticks arrive both while the sequencer is checking and while it is waiting. Directed cases cover:
- a long stall with no tick;
- starts and bus changes in the middle of a move;
- ticks while idle;
- a reset in the middle of a move.

// File: rtl/dda_pkg.sv
package dda_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_ACCUM = 2'd2
  } dda_state_e;

endpackage

// File: rtl/dda_axis_acc.sv
module dda_axis_acc #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [ACC_W-1:0] incr_i,
  output logic             pulse_o
);

  logic [ACC_W-1:0] incr_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, incr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      incr_q  <= '0;
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else if (load_i) begin
      incr_q  <= incr_i;
      acc_q   <= '0;
      pulse_o <= 1'b0;
    end else if (step_i) begin
      acc_q   <= sum[ACC_W-1:0];
      pulse_o <= sum[ACC_W];
    end else begin
      pulse_o <= 1'b0;
    end
  end

endmodule

// File: rtl/dda_step_seq.sv
module dda_step_seq
  import dda_pkg::*;
#(
  parameter int ACC_W = 8,
  localparam int CNT_W = ACC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  output logic             load_o,
  output logic             step_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] steps_left_o
);

  localparam logic [CNT_W-1:0] FULL_COUNT = {1'b1, {ACC_W{1'b0}}};

  dda_state_e       state_q;
  logic [CNT_W-1:0] left_q;
  logic             busy_q;

  assign load_o       = (state_q == ST_IDLE) && start_i;
  assign step_o       = (state_q == ST_ACCUM) && tick_i;
  assign busy_o       = busy_q;
  assign steps_left_o = left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_CHECK;
            left_q  <= FULL_COUNT;
            busy_q  <= 1'b1;
          end
        end
        ST_CHECK: begin
          if (left_q != '0) begin
            state_q <= ST_ACCUM;
          end else begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end
        end
        ST_ACCUM: begin
          if (tick_i) begin
            state_q <= ST_CHECK;
            left_q  <= left_q - 1'b1;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          busy_q  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dda_pulse_gen.sv
module dda_pulse_gen #(
  parameter int NUM_AXES = 4,
  parameter int ACC_W    = 8,
  localparam int CNT_W   = ACC_W + 1,
  localparam int BUS_W   = NUM_AXES * ACC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                tick_i,
  input  logic [BUS_W-1:0]    incr_i,
  output logic                busy_o,
  output logic [NUM_AXES-1:0] pulse_o,
  output logic [CNT_W-1:0]    steps_left_o
);

  logic load;
  logic step;

  dda_step_seq #(.ACC_W(ACC_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .tick_i       (tick_i),
    .load_o       (load),
    .step_o       (step),
    .busy_o       (busy_o),
    .steps_left_o (steps_left_o)
  );

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
    dda_axis_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .step_i  (step),
      .incr_i  (incr_i[a*ACC_W +: ACC_W]),
      .pulse_o (pulse_o[a])
    );
  end

endmodule

// File: rtl/dda_pulse_gen_chk.sv
module dda_pulse_gen_chk #(
  parameter int NUM_AXES = 4,
  parameter int ACC_W    = 8,
  localparam int CNT_W   = ACC_W + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                tick_i,
  input logic                busy_o,
  input logic [NUM_AXES-1:0] pulse_o,
  input logic [CNT_W-1:0]    steps_left_o
);

  localparam logic [CNT_W-1:0] FULL_COUNT = {1'b1, {ACC_W{1'b0}}};

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && steps_left_o == FULL_COUNT));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> (!busy_o && pulse_o == '0));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_o) |=> (pulse_o == '0));

  assert_pulse_in_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_o) |-> busy_o);

  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i) |=> ($stable(steps_left_o) && pulse_o == '0));

  assert_step_by_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (steps_left_o == $past(steps_left_o) ||
                steps_left_o == $past(steps_left_o) - 1'b1));

  assert_no_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && steps_left_o < FULL_COUNT) |=> (steps_left_o < FULL_COUNT));

endmodule

bind dda_pulse_gen dda_pulse_gen_chk #(.NUM_AXES(NUM_AXES), .ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .tick_i       (tick_i),
  .busy_o       (busy_o),
  .pulse_o      (pulse_o),
  .steps_left_o (steps_left_o)
);

// File: tb/test_dda_pulse_gen.sv
module test_dda_pulse_gen;

  localparam int CLK_PERIOD = 10;
  localparam int AXES       = 4;
  localparam int AW         = 4;
  localparam int CW         = AW + 1;
  localparam int TOTAL      = 1 << AW;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_i = 1'b0;
  logic               tick_i = 1'b0;
  logic [AXES*AW-1:0] incr_i = '0;
  logic               busy_o;
  logic [AXES-1:0]    pulse_o;
  logic [CW-1:0]      steps_left_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // entries: {tick gap[3:0], increments[15:0]}, axis 0 in the low nibble
  localparam int NVEC = 6;
  localparam logic [19:0] VEC [NVEC] = '{
    20'h1_3A15, 20'h3_F0F0, 20'h2_8421,
    20'h1_FFFF, 20'h1_0000, 20'h5_7C9E
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  dda_pulse_gen #(.NUM_AXES(AXES), .ACC_W(AW)) i_dda_pulse_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .tick_i       (tick_i),
    .incr_i       (incr_i),
    .busy_o       (busy_o),
    .pulse_o      (pulse_o),
    .steps_left_o (steps_left_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // runs one move; disturb=1 toggles the increment bus and fires start mid-move
  task automatic run_move(input logic [AXES*AW-1:0] incr, input int gap,
                          input bit disturb, input string tag);
    int cnt [AXES];
    int prev_any = 0;
    int cyc = 0;
    int back2back = 0;
    foreach (cnt[a]) cnt[a] = 0;
    @(negedge clk);
    incr_i  = incr;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({"R2 busy after start ", tag}, int'(busy_o), 1);
    check({"R2 count loaded ", tag}, int'(steps_left_o), TOTAL);
    while (busy_o && cyc < 2000) begin
      for (int a = 0; a < AXES; a++) if (pulse_o[a]) cnt[a]++;
      if (prev_any != 0 && pulse_o != '0) back2back++;
      prev_any = int'(|pulse_o);
      tick_i = ((cyc % gap) == 0);
      if (disturb) begin
        incr_i  = ~incr;
        start_i = (cyc % 7 == 3);
      end
      cyc++;
      @(negedge clk);
    end
    tick_i  = 1'b0;
    start_i = 1'b0;
    check({"R7 move completes ", tag}, int'(busy_o), 0);
    check({"R7 count at end ", tag}, int'(steps_left_o), 0);
    check({"R4 no back-to-back pulses ", tag}, back2back, 0);
    for (int a = 0; a < AXES; a++)
      check({"R3 pulse total ", tag}, cnt[a], int'(incr[a*AW +: AW]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 pulses in reset", int'(pulse_o), 0);
    check("R1 count in reset", int'(steps_left_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after reset", int'(busy_o), 0);

    for (int v = 0; v < NVEC; v++)
      run_move(VEC[v][15:0], int'(VEC[v][19:16]), 1'b0, $sformatf("vec%0d", v));

    // R9: extremes of the increment range on different axes
    run_move(16'h0F00, 1, 1'b0, "R9 extremes");

    // R6 and R8: start and bus changes during a move are ignored
    run_move(16'h5B26, 2, 1'b1, "R6 R8 disturb");

    // R5: stall with tick held low
    begin
      int seen = 0;
      @(negedge clk);
      incr_i = 16'hFFFF;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 20; i++) begin
        if (pulse_o != '0) seen++;
        @(negedge clk);
      end
      check("R5 count held without tick", int'(steps_left_o), TOTAL);
      check("R5 no pulses without tick", seen, 0);
      check("R5 still busy", int'(busy_o), 1);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      check("R7 one tick one step", int'(steps_left_o), TOTAL - 1);
      // reset in mid-move returns to the reset state
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-move reset busy", int'(busy_o), 0);
      check("R1 mid-move reset count", int'(steps_left_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
    end

    // R10: ticks while idle
    begin
      int seen = 0;
      tick_i = 1'b1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (busy_o || pulse_o != '0 || steps_left_o != '0) seen++;
      end
      tick_i = 1'b0;
      check("R10 idle ticks ignored", seen, 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule